// File: doc/BRIEF.md
# Flash Command Sequencer with Access-Order Checking

The sequencer stands between the system bus and a flash programming engine. Software starts a flash operation in three steps. It writes a data byte to a flash array address. It writes a command code to the command register. It then writes the status register with the go bit set. The block records the address, the data and the command. On the go write it sends them to the engine with a one-cycle launch strobe. While the engine works, the command-buffer-empty indication (`cbe`) stays low. It rises again after the engine's busy input falls.

Any access that breaks this order, or any command that is not allowed, sets a sticky access-error flag. The partial command is then discarded. Software clears the flag by writing the status register with the clear bit set. While the flag is set, attempts to start a new command are ignored. Entering stop mode while the engine is busy aborts the operation. The device-secured and debug-source inputs restrict which commands the debug port may issue.

The controller has four states:
- IDLE: waiting for a flash array write.
- ADDR_WRITTEN: address and data captured.
- CMD_WRITTEN: command code accepted.
- BUSY: command launched.

The transitions between them are:
- IDLE goes to ADDR_WRITTEN on an accepted flash array write.
- ADDR_WRITTEN goes to CMD_WRITTEN on a permitted command write.
- CMD_WRITTEN goes to BUSY on a status write with the go bit set.
- BUSY goes to IDLE on the busy input falling, or on an abort caused by stop mode.
- ADDR_WRITTEN and CMD_WRITTEN go to IDLE on any access error.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset:
  - The state is IDLE.
  - `cbe`=1, `acc_err`=0, `div_set`=0, `launch`=0 and `eng_abort`=0.
- R2: A control write with `reg_sel`=0 (clock divider) sets `div_set`, which stays set. A flash array write made while `div_set`=0 sets `acc_err`.
- R3: Launching a command takes three accesses:
  - a flash array write, then
  - a write to the command register (`reg_sel`=2) with a permitted code, then
  - a status write (`reg_sel`=1) with bit 7 = 1.
  
  In the cycle after the status write, `launch` is 1 for one cycle. In that cycle `launch_addr`, `launch_data` and `launch_cmd` carry the captured values, and `cbe` is 0.
- R4: Only the codes 0x05, 0x20, 0x25, 0x40 and 0x41 are permitted. Any other code written to the command register sets `acc_err` and returns to IDLE.
- R5: Each of the following sets `acc_err` and returns to IDLE:
  - a second flash array write before launch,
  - a second command write,
  - a command write in IDLE while `acc_err`=0.
- R6: In ADDR_WRITTEN, a write to any control register other than the command register sets `acc_err`. Control reads in that state have no effect.
- R7: In CMD_WRITTEN, each of the following sets `acc_err` without a launch:
  - any control read,
  - any control write other than a status write with bit 7 = 1, including a status write with bit 7 = 0 (cancel).
- R8: A flash array write during BUSY sets `acc_err`. The running command continues and `cbe` stays 0.
- R9: When `stop_req`=1 in BUSY:
  - `eng_abort` pulses for one cycle,
  - `acc_err` is set,
  - the state returns to IDLE, so `cbe` is 1 in the abort cycle.
- R10: When `secured`=1 and `dbg_src`=1 at the command write:
  - codes 0x20, 0x25 and 0x40 set `acc_err`,
  - codes 0x05 and 0x41 are accepted.
  
  With either input 0, all five codes are accepted.
- R11: Once set, `acc_err` holds until a status write with bit 4 = 1 in IDLE or BUSY clears it. While it is set, the following are ignored and no launch occurs:
  - flash array writes in IDLE,
  - command writes in IDLE,
  - status go writes in IDLE.
- R12: BUSY ends when `eng_busy` is sampled 0 after having been sampled 1. `cbe` is 1 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arr_wr | input | 1 | Write strobe to the flash array space |
| arr_addr | input | ADDR_W | Flash array address of the write |
| arr_wdata | input | DATA_W | Flash array write data |
| reg_wr | input | 1 | Control register write strobe |
| reg_rd | input | 1 | Control register read strobe |
| reg_sel | input | 2 | Control register: 0 divider, 1 status, 2 command, 3 other |
| reg_wdata | input | 8 | Control write data (status: bit 7 go, bit 4 clear error) |
| stop_req | input | 1 | Device entering stop mode |
| secured | input | 1 | Device is secured |
| dbg_src | input | 1 | Current access comes from the debug port |
| eng_busy | input | 1 | Flash engine busy |
| launch | output | 1 | One-cycle command launch strobe |
| launch_addr | output | ADDR_W | Captured flash address |
| launch_data | output | DATA_W | Captured data byte |
| launch_cmd | output | 8 | Captured command code |
| eng_abort | output | 1 | One-cycle abort strobe to the engine |
| cbe | output | 1 | Command buffer empty (0 while BUSY) |
| acc_err | output | 1 | Sticky access-error flag |
| div_set | output | 1 | Clock divider has been written |

## Verification
The checker assumes that at most one of `arr_wr`, `reg_wr` and `reg_rd` is high in any cycle. The stimulus issues every bus access as a separate single-cycle strobe. The completion and abort properties rely on the engine model in the stimulus. That model raises `eng_busy` only after a launch and lowers it after a few cycles or on abort. `stop_req` is asserted only briefly during a busy period. The secured and debug-source inputs are changed only between command sequences.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    localparam int REG_W = 8;
    localparam int OP_W  = 8;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_ADDR = 2'd1,
        SEQ_CMD  = 2'd2,
        SEQ_BUSY = 2'd3
    } seq_state_t;

    // control register selects
    localparam logic [1:0] SEL_DIV  = 2'd0;
    localparam logic [1:0] SEL_STAT = 2'd1;
    localparam logic [1:0] SEL_CMD  = 2'd2;

    // status write bits
    localparam int STAT_GO_BIT  = 7;
    localparam int STAT_CLR_BIT = 4;

    // permitted operation codes; index order matters for SECURE_OK_MASK
    localparam int NUM_OPS = 5;
    localparam logic [OP_W-1:0] OP_TABLE [NUM_OPS] = '{
        8'h05,  // blank check
        8'h20,  // byte program
        8'h25,  // burst program
        8'h40,  // page erase
        8'h41   // mass erase
    };
    localparam logic [NUM_OPS-1:0] SECURE_OK_MASK = 5'b10001;

    function automatic logic op_known(input logic [OP_W-1:0] c);
        logic hit;
        hit = 1'b0;
        for (int i = 0; i < NUM_OPS; i++) begin
            if (c == OP_TABLE[i]) hit = 1'b1;
        end
        return hit;
    endfunction

endpackage

// File: rtl/fcs_op_check.sv
module fcs_op_check
    import fcs_pkg::*;
(
    input  logic [OP_W-1:0] op,
    input  logic            secured,
    input  logic            dbg_src,
    output logic            op_ok
);
    logic [NUM_OPS-1:0] hit;

    genvar g;
    generate
        for (g = 0; g < NUM_OPS; g++) begin : g_match
            assign hit[g] = (op == OP_TABLE[g]);
        end
    endgenerate

    logic restricted;
    assign restricted = secured & dbg_src;

    assign op_ok = (|hit) & (~restricted | (|(hit & SECURE_OK_MASK)));
endmodule

// File: rtl/fcs_capture.sv
module fcs_capture
    import fcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_addr,
    input  logic              load_op,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic [OP_W-1:0]   op_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q,
    output logic [OP_W-1:0]   op_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (load_addr) begin
            addr_q <= addr_in;
            data_q <= data_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       op_q <= '0;
        else if (load_op) op_q <= op_in;
    end
endmodule

// File: rtl/fcs_fsm.sv
module fcs_fsm
    import fcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arr_wr,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [1:0] reg_sel,
    input  logic       go_bit,
    input  logic       clr_bit,
    input  logic       op_ok,
    input  logic       stop_req,
    input  logic       eng_busy,
    output logic       load_addr,
    output logic       load_op,
    output logic       launch,
    output logic       eng_abort,
    output logic       acc_err,
    output logic       div_set,
    output logic       cbe
);
    seq_state_t state, nxt;
    logic err_ev, clr_ev, div_ev, go_ev, abort_ev;
    logic busy_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SEQ_IDLE;
        else        state <= nxt;
    end

    // next state and events
    always_comb begin
        nxt       = state;
        err_ev    = 1'b0;
        clr_ev    = 1'b0;
        div_ev    = 1'b0;
        go_ev     = 1'b0;
        abort_ev  = 1'b0;
        load_addr = 1'b0;
        load_op   = 1'b0;
        unique case (state)
            SEQ_IDLE: begin
                if (arr_wr) begin
                    if (!acc_err) begin
                        if (!div_set) begin
                            err_ev = 1'b1;
                        end else begin
                            load_addr = 1'b1;
                            nxt       = SEQ_ADDR;
                        end
                    end
                end else if (reg_wr) begin
                    if (reg_sel == SEL_DIV)       div_ev = 1'b1;
                    else if (reg_sel == SEL_STAT) clr_ev = clr_bit;
                    else if (reg_sel == SEL_CMD)  err_ev = ~acc_err;
                end
            end
            SEQ_ADDR: begin
                if (arr_wr) begin
                    err_ev = 1'b1;
                end else if (reg_wr) begin
                    if (reg_sel == SEL_CMD && op_ok) begin
                        load_op = 1'b1;
                        nxt     = SEQ_CMD;
                    end else begin
                        err_ev = 1'b1;
                    end
                end
            end
            SEQ_CMD: begin
                if (arr_wr || reg_rd) begin
                    err_ev = 1'b1;
                end else if (reg_wr) begin
                    if (reg_sel == SEL_STAT && go_bit) begin
                        go_ev = 1'b1;
                        nxt   = SEQ_BUSY;
                    end else begin
                        err_ev = 1'b1;
                    end
                end
            end
            SEQ_BUSY: begin
                if (stop_req) begin
                    abort_ev = 1'b1;
                    err_ev   = 1'b1;
                    nxt      = SEQ_IDLE;
                end else begin
                    if (busy_q && !eng_busy) nxt = SEQ_IDLE;
                    if (arr_wr) err_ev = 1'b1;
                    else if (reg_wr && reg_sel == SEL_STAT) clr_ev = clr_bit;
                end
            end
        endcase
        if (err_ev && state != SEQ_BUSY) nxt = SEQ_IDLE;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_err   <= 1'b0;
            div_set   <= 1'b0;
            launch    <= 1'b0;
            eng_abort <= 1'b0;
            busy_q    <= 1'b0;
        end else begin
            if (err_ev)      acc_err <= 1'b1;
            else if (clr_ev) acc_err <= 1'b0;
            if (div_ev) div_set <= 1'b1;
            launch    <= go_ev;
            eng_abort <= abort_ev;
            busy_q    <= eng_busy;
        end
    end

    assign cbe = (state != SEQ_BUSY);
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import fcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arr_wr,
    input  logic [ADDR_W-1:0] arr_addr,
    input  logic [DATA_W-1:0] arr_wdata,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              stop_req,
    input  logic              secured,
    input  logic              dbg_src,
    input  logic              eng_busy,
    output logic              launch,
    output logic [ADDR_W-1:0] launch_addr,
    output logic [DATA_W-1:0] launch_data,
    output logic [OP_W-1:0]   launch_cmd,
    output logic              eng_abort,
    output logic              cbe,
    output logic              acc_err,
    output logic              div_set
);
    logic op_ok, load_addr, load_op;

    fcs_op_check u_check (
        .op      (reg_wdata),
        .secured (secured),
        .dbg_src (dbg_src),
        .op_ok   (op_ok)
    );

    fcs_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .arr_wr    (arr_wr),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_sel   (reg_sel),
        .go_bit    (reg_wdata[STAT_GO_BIT]),
        .clr_bit   (reg_wdata[STAT_CLR_BIT]),
        .op_ok     (op_ok),
        .stop_req  (stop_req),
        .eng_busy  (eng_busy),
        .load_addr (load_addr),
        .load_op   (load_op),
        .launch    (launch),
        .eng_abort (eng_abort),
        .acc_err   (acc_err),
        .div_set   (div_set),
        .cbe       (cbe)
    );

    fcs_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_addr (load_addr),
        .load_op   (load_op),
        .addr_in   (arr_addr),
        .data_in   (arr_wdata),
        .op_in     (reg_wdata),
        .addr_q    (launch_addr),
        .data_q    (launch_data),
        .op_q      (launch_cmd)
    );
endmodule

// File: rtl/fcs_sva.sv
module fcs_sva
    import fcs_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             arr_wr,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic [1:0]       reg_sel,
    input logic [REG_W-1:0] reg_wdata,
    input logic             stop_req,
    input logic             eng_busy,
    input logic             launch,
    input logic [OP_W-1:0]  launch_cmd,
    input logic             eng_abort,
    input logic             cbe,
    input logic             acc_err
);
    // input assumption: one bus access per cycle
    one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({arr_wr, reg_wr, reg_rd}));

    // R3
    launch_after_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> $past(reg_wr && reg_sel == SEL_STAT && reg_wdata[STAT_GO_BIT]));

    // R3
    launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> !cbe);

    // R4
    launch_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> op_known(launch_cmd));

    // R11
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(acc_err) |-> $past(reg_wr && reg_sel == SEL_STAT && reg_wdata[STAT_CLR_BIT]));

    // R11
    no_launch_in_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> !$past(acc_err));

    // R9
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_abort |-> (acc_err && cbe && $past(stop_req)));

    // R12
    cbe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cbe) |-> (eng_abort || $past(!eng_busy)));
endmodule

bind flash_cmd_seq fcs_sva u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .arr_wr     (arr_wr),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .stop_req   (stop_req),
    .eng_busy   (eng_busy),
    .launch     (launch),
    .launch_cmd (launch_cmd),
    .eng_abort  (eng_abort),
    .cbe        (cbe),
    .acc_err    (acc_err)
);

// File: tb/sim_flash_cmd_seq.sv
module sim_flash_cmd_seq;
    localparam int AW = 16;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          arr_wr = 1'b0;
    logic [AW-1:0] arr_addr = '0;
    logic [DW-1:0] arr_wdata = '0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [1:0]    reg_sel = 2'd0;
    logic [7:0]    reg_wdata = 8'h00;
    logic          stop_req = 1'b0;
    logic          secured = 1'b0;
    logic          dbg_src = 1'b0;
    logic          eng_busy = 1'b0;
    logic          launch, eng_abort, cbe, acc_err, div_set;
    logic [AW-1:0] launch_addr;
    logic [DW-1:0] launch_data;
    logic [7:0]    launch_cmd;

    flash_cmd_seq #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .arr_wr(arr_wr), .arr_addr(arr_addr),
        .arr_wdata(arr_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .stop_req(stop_req),
        .secured(secured), .dbg_src(dbg_src), .eng_busy(eng_busy),
        .launch(launch), .launch_addr(launch_addr), .launch_data(launch_data),
        .launch_cmd(launch_cmd), .eng_abort(eng_abort), .cbe(cbe),
        .acc_err(acc_err), .div_set(div_set)
    );

    int    n_checks = 0;
    int    n_errs = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    // behavioural reference: 0 idle, 1 addr, 2 cmd, 3 busy
    int            m_st = 0;
    int            m_nx;
    bit            m_err, m_div, m_go, m_abort, m_busyq, m_e, m_clr;
    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] m_data = '0;
    logic [7:0]    m_cmd = '0;

    function automatic bit m_allowed(input logic [7:0] c, input bit sec, input bit dbg);
        bit known;
        known = (c == 8'h05) || (c == 8'h20) || (c == 8'h25) || (c == 8'h40) || (c == 8'h41);
        if (!known) return 1'b0;
        if (sec && dbg && !(c == 8'h05 || c == 8'h41)) return 1'b0;
        return 1'b1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_err = 0; m_div = 0; m_go = 0; m_abort = 0; m_busyq = 0;
        end else begin
            m_e = 0; m_clr = 0; m_nx = m_st; m_go = 0; m_abort = 0;
            if (m_st == 0) begin
                if (arr_wr) begin
                    if (!m_err) begin
                        if (!m_div) m_e = 1;
                        else begin m_addr = arr_addr; m_data = arr_wdata; m_nx = 1; end
                    end
                end else if (reg_wr) begin
                    if (reg_sel == 2'd0) m_div = 1;
                    else if (reg_sel == 2'd1) m_clr = reg_wdata[4];
                    else if (reg_sel == 2'd2 && !m_err) m_e = 1;
                end
            end else if (m_st == 1) begin
                if (arr_wr) m_e = 1;
                else if (reg_wr) begin
                    if (reg_sel == 2'd2 && m_allowed(reg_wdata, secured, dbg_src)) begin
                        m_cmd = reg_wdata; m_nx = 2;
                    end else m_e = 1;
                end
            end else if (m_st == 2) begin
                if (arr_wr || reg_rd) m_e = 1;
                else if (reg_wr) begin
                    if (reg_sel == 2'd1 && reg_wdata[7]) begin m_go = 1; m_nx = 3; end
                    else m_e = 1;
                end
            end else begin
                if (stop_req) begin m_abort = 1; m_e = 1; m_nx = 0; end
                else begin
                    if (m_busyq && !eng_busy) m_nx = 0;
                    if (arr_wr) m_e = 1;
                    else if (reg_wr && reg_sel == 2'd1) m_clr = reg_wdata[4];
                end
            end
            if (m_e && m_st != 3) m_nx = 0;
            if (m_e) m_err = 1; else if (m_clr) m_err = 0;
            m_st = m_nx;
            m_busyq = eng_busy;
        end
    end

    task automatic compare();
        bit bad;
        bad = (cbe != (m_st != 3)) || (acc_err != m_err) || (div_set != m_div) ||
              (launch != m_go) || (eng_abort != m_abort) ||
              (m_go && (launch_addr != m_addr || launch_data != m_data || launch_cmd != m_cmd));
        n_checks++;
        if (bad) begin
            n_errs++;
            $display("FAIL %s: cbe=%0b/%0b err=%0b/%0b div=%0b/%0b launch=%0b/%0b abort=%0b/%0b addr=%h/%h data=%h/%h cmd=%h/%h (actual/expected)",
                     cur_req, cbe, (m_st != 3), acc_err, m_err, div_set, m_div, launch, m_go,
                     eng_abort, m_abort, launch_addr, m_addr, launch_data, m_data, launch_cmd, m_cmd);
        end
    endtask

    task automatic expect_val(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr_arr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        arr_wr = 1; arr_addr = a; arr_wdata = d; tick(); arr_wr = 0;
    endtask

    task automatic wr_reg(input logic [1:0] s, input logic [7:0] d);
        reg_wr = 1; reg_sel = s; reg_wdata = d; tick(); reg_wr = 0;
    endtask

    task automatic rd_reg(input logic [1:0] s);
        reg_rd = 1; reg_sel = s; tick(); reg_rd = 0;
    endtask

    task automatic clr_err();
        wr_reg(2'd1, 8'h10);
    endtask

    task automatic to_cmd(input logic [7:0] c);
        wr_arr(16'h2000, 8'h3C);
        wr_reg(2'd2, c);
    endtask

    task automatic go_run(input string req, input logic [7:0] c);
        wr_reg(2'd1, 8'h80);
        expect_val(req, "launch", launch, 1);
        expect_val(req, "launch_cmd", launch_cmd, c);
        eng_busy = 1; idle(2); eng_busy = 0; idle(1);
        expect_val("R12", "cbe after busy falls", cbe, 1);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_errs++;
            $display("FAIL watchdog: run hung actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] good_ops [5];
        logic [7:0] bad_ops  [4];
        good_ops = '{8'h05, 8'h20, 8'h25, 8'h40, 8'h41};
        bad_ops  = '{8'h00, 8'h21, 8'hFF, 8'h42};

        repeat (3) @(negedge clk);
        // R1 reset state
        expect_val("R1", "cbe", cbe, 1);
        expect_val("R1", "acc_err", acc_err, 0);
        expect_val("R1", "div_set", div_set, 0);
        expect_val("R1", "launch", launch, 0);
        rst_n = 1;
        idle(2);

        // R2 flash write before divider
        cur_req = "R2";
        wr_arr(16'h0100, 8'hA5);
        expect_val("R2", "acc_err", acc_err, 1);
        clr_err();
        expect_val("R11", "acc_err cleared", acc_err, 0);
        wr_reg(2'd0, 8'h13);
        expect_val("R2", "div_set", div_set, 1);

        // R3 + R12 normal launch
        cur_req = "R3";
        wr_arr(16'h1234, 8'h5A);
        wr_reg(2'd2, 8'h20);
        wr_reg(2'd1, 8'h80);
        expect_val("R3", "launch", launch, 1);
        expect_val("R3", "launch_addr", launch_addr, 16'h1234);
        expect_val("R3", "launch_data", launch_data, 8'h5A);
        expect_val("R3", "launch_cmd", launch_cmd, 8'h20);
        expect_val("R3", "cbe", cbe, 0);
        cur_req = "R12";
        eng_busy = 1; idle(3);
        expect_val("R12", "cbe during busy", cbe, 0);
        eng_busy = 0; idle(1);
        expect_val("R12", "cbe after busy", cbe, 1);

        // R4 permitted and refused codes
        cur_req = "R4";
        foreach (good_ops[i]) begin
            to_cmd(good_ops[i]);
            go_run("R4", good_ops[i]);
        end
        foreach (bad_ops[i]) begin
            to_cmd(bad_ops[i]);
            expect_val("R4", "acc_err on bad code", acc_err, 1);
            expect_val("R4", "cbe", cbe, 1);
            clr_err();
        end

        // R5 duplicate accesses
        cur_req = "R5";
        wr_arr(16'h0010, 8'h01); wr_arr(16'h0011, 8'h02);
        expect_val("R5", "second flash write", acc_err, 1);
        clr_err();
        to_cmd(8'h05); wr_reg(2'd2, 8'h05);
        expect_val("R5", "second command write", acc_err, 1);
        clr_err();
        wr_reg(2'd2, 8'h05);
        expect_val("R5", "command without address", acc_err, 1);
        clr_err();

        // R6 control access after address write
        cur_req = "R6";
        wr_arr(16'h0020, 8'h11); wr_reg(2'd0, 8'h13);
        expect_val("R6", "divider write", acc_err, 1);
        clr_err();
        wr_arr(16'h0020, 8'h11); wr_reg(2'd1, 8'h80);
        expect_val("R6", "status write", acc_err, 1);
        clr_err();
        wr_arr(16'h0020, 8'h11); wr_reg(2'd3, 8'h00);
        expect_val("R6", "other write", acc_err, 1);
        clr_err();
        wr_arr(16'h0030, 8'h22); rd_reg(2'd1);
        expect_val("R6", "read allowed", acc_err, 0);
        wr_reg(2'd2, 8'h41);
        go_run("R6", 8'h41);

        // R7 access after command write
        cur_req = "R7";
        to_cmd(8'h20); rd_reg(2'd1);
        expect_val("R7", "status read", acc_err, 1);
        clr_err();
        to_cmd(8'h20); wr_reg(2'd1, 8'h00);
        expect_val("R7", "cancel write", acc_err, 1);
        expect_val("R7", "no launch", launch, 0);
        clr_err();
        to_cmd(8'h20); wr_reg(2'd0, 8'h13);
        expect_val("R7", "divider write", acc_err, 1);
        clr_err();

        // R8 flash write while busy
        cur_req = "R8";
        to_cmd(8'h25); wr_reg(2'd1, 8'h80);
        eng_busy = 1; idle(1);
        wr_arr(16'h0040, 8'h33);
        expect_val("R8", "acc_err", acc_err, 1);
        expect_val("R8", "cbe stays low", cbe, 0);
        eng_busy = 0; idle(1);
        expect_val("R8", "cbe after busy", cbe, 1);
        clr_err();

        // R9 stop during busy
        cur_req = "R9";
        to_cmd(8'h40); wr_reg(2'd1, 8'h80);
        eng_busy = 1; idle(1);
        stop_req = 1; tick(); stop_req = 0;
        expect_val("R9", "eng_abort", eng_abort, 1);
        expect_val("R9", "acc_err", acc_err, 1);
        expect_val("R9", "cbe", cbe, 1);
        eng_busy = 0; idle(2);
        expect_val("R9", "abort one cycle", eng_abort, 0);
        clr_err();

        // R10 secured debug rules
        cur_req = "R10";
        secured = 1; dbg_src = 1;
        to_cmd(8'h20); expect_val("R10", "0x20 refused", acc_err, 1); clr_err();
        to_cmd(8'h25); expect_val("R10", "0x25 refused", acc_err, 1); clr_err();
        to_cmd(8'h40); expect_val("R10", "0x40 refused", acc_err, 1); clr_err();
        to_cmd(8'h05); go_run("R10", 8'h05);
        to_cmd(8'h41); go_run("R10", 8'h41);
        dbg_src = 0;
        to_cmd(8'h20); go_run("R10", 8'h20);
        secured = 0; dbg_src = 1;
        to_cmd(8'h40); go_run("R10", 8'h40);
        dbg_src = 0;

        // R11 sticky error ignores new sequences
        cur_req = "R11";
        wr_reg(2'd2, 8'h05);
        expect_val("R11", "error set", acc_err, 1);
        wr_arr(16'h0050, 8'h44);
        wr_reg(2'd2, 8'h20);
        wr_reg(2'd1, 8'h80);
        expect_val("R11", "no launch", launch, 0);
        expect_val("R11", "cbe", cbe, 1);
        expect_val("R11", "still set", acc_err, 1);
        clr_err();
        to_cmd(8'h20); go_run("R11", 8'h20);
        to_cmd(8'h41); wr_reg(2'd1, 8'h80);
        eng_busy = 1; wr_arr(16'h0060, 8'h55);
        expect_val("R11", "busy error", acc_err, 1);
        clr_err();
        expect_val("R11", "cleared in busy", acc_err, 0);
        expect_val("R11", "busy kept", cbe, 0);
        eng_busy = 0; idle(2);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule